// File: doc/BRIEF.md
# Snoop-Priority Cache Tag Array

This block holds the tags and coherence states for a four-way set-associative data cache of 16 KB. The cache uses physical addresses. Each line is 32 bytes, so a 32-bit address splits into a 20-bit tag, a 7-bit set index and a 5-bit byte offset. Two requesters share one lookup port. The core side issues load/store lookups and line-fill writes. The bus side issues snoop lookups, which may also invalidate the line they hit. Each lookup returns hit, hit way and line state one clock after it is made, on a result path of its own.

When both sides ask for the port in the same clock, the snoop always goes first. The core operation is held inside the block and performed on the next clock. A `core_busy` flag marks that clock, and the core must not count on a new request being taken while it is high. Replacement uses a three-bit tree per set. Core hits and fills update it. Snoops do not. A fill prefers an invalid way over the tree's choice. The block holds no line data and does not sequence refills or bus transactions.

Top module: `cache_tag_array`

## Requirements
- R1: After a synchronous active-low reset, every way of every set is invalid, the replacement tree of every set is all-zero, and `core_rsp_valid`, `snp_rsp_valid` and `core_busy` are low.
- R2: An address is decoded as tag = bits 31:12 and set = bits 11:5. Bits 4:0 have no effect on any lookup or fill.
- R3: A core lookup performed in clock t raises `core_rsp_valid` in clock t+1, with `core_hit`, `core_way` (0..3) and `core_state`. On a miss, way and state read 0.
- R4: A snoop presented in clock t raises `snp_rsp_valid` in clock t+1, with `snp_hit`, `snp_way` and `snp_state`. On a hit, the state reported is the one held before any invalidation.
- R5: If `core_req` and `snp_req` are both high while `core_busy` is low, the snoop is looked up in that clock. `core_busy` is then high in the next clock, the core operation is performed in that clock, and its result appears two clocks after the request. The core and snoop result strobes are never high together.
- R6: A `core_req` presented while `core_busy` is high is ignored. It produces no result and changes no stored tag or state.
- R7: A snoop with `snp_inv` high that hits sets that way to invalid. A later core lookup of the same line misses.
- R8: A snoop lookup never changes the replacement tree.
- R9: A fill (`core_fill` high) whose tag is absent installs tag and `core_fill_state` into the lowest-numbered invalid way of the set. If no way is invalid, it uses the way the tree selects. The response reports `core_hit`=0, the installed way and the installed state.
- R10: Tree bits {b2,b1,b0} point at the less recently used side. The victim is way 0/1 (chosen by b1) when b0=0, and way 2/3 (chosen by b2) when b0=1. A core hit or fill on way w sets b0=1 for w<2 and 0 otherwise. For w<2 it sets b1=(w==0); for w>=2 it sets b2=(w==2).
- R11: Line state is encoded 00 invalid, 01 shared, 10 exclusive, 11 modified. Only a non-invalid way with a matching tag hits, and at most one way hits.
- R12: A fill whose tag already hits in the set overwrites that way's state in place. It reports `core_hit`=1 and that way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core lookup or fill request |
| core_fill | input | 1 | Request is a line fill write |
| core_addr | input | 32 | Core physical address |
| core_fill_state | input | 2 | State to install on a fill |
| core_busy | output | 1 | Deferred core operation occupies the port this clock |
| snp_req | input | 1 | Snoop lookup request |
| snp_inv | input | 1 | Snoop invalidates the line on a hit |
| snp_addr | input | 32 | Snooped physical address |
| core_rsp_valid | output | 1 | Core result strobe |
| core_hit | output | 1 | Core lookup hit |
| core_way | output | 2 | Hit or installed way |
| core_state | output | 2 | Hit or installed state |
| snp_rsp_valid | output | 1 | Snoop result strobe |
| snp_hit | output | 1 | Snoop lookup hit |
| snp_way | output | 2 | Snoop hit way |
| snp_state | output | 2 | State prior to any invalidation |

## Verification
The hardest case to reach is a collision in which the snoop invalidates the very line the deferred core access wants. The core must then miss on its replay clock. While the replay is pending, a competing core request must be dropped. The bench builds this case directly. It fills a known line, then drives the core lookup and an invalidating snoop of that line in the same clock. It drives a different core request during the busy clock and checks that no third result strobe follows. A reference model of tags, states and replacement trees predicts every way choice across sweeps of all 128 sets and across eviction chains.

// File: rtl/cache_tag_pkg.sv
// Shared constants and helpers for the cache tag array.
// Assumes a fixed four-way organisation with a three-bit replacement tree.
package cache_tag_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int TREE_W = 3;

    typedef enum logic [1:0] {
        LS_INVALID = 2'b00,
        LS_SHARED  = 2'b01,
        LS_EXCL    = 2'b10,
        LS_MOD     = 2'b11
    } line_state_e;

    // Encode a zero- or one-hot way vector to an index (0 when empty).
    function automatic logic [WAY_W-1:0] way_index(input logic [WAYS-1:0] vec);
        logic [WAY_W-1:0] idx;
        idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vec[w]) idx = WAY_W'(w);
        end
        return idx;
    endfunction
endpackage

// File: rtl/cache_tag_store.sv
// Tag and state storage with a combinational compare for one lookup port.
// Assumes one write per clock; state is reset, tags are not (state masks them).
module cache_tag_store
    import cache_tag_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [TAG_W-1:0]           rd_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic [WAYS-1:0][1:0]       rd_state,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [1:0]                 wr_state
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [1:0]       st_q  [SETS][WAYS];

    // Tag write on fill or invalidation.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    // State write; reset clears every way to invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    st_q[s][w] <= LS_INVALID;
        end else if (wr_en) begin
            st_q[wr_idx][wr_way] <= wr_state;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        // Per-way compare against the presented tag.
        always_comb begin
            rd_state[w] = st_q[rd_idx][w];
            hit_vec[w]  = (st_q[rd_idx][w] != LS_INVALID) && (tag_q[rd_idx][w] == rd_tag);
        end
    end

    // R11: no two valid ways of a set hold the same tag.
    p_single_hit_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/cache_tag_plru.sv
// Per-set three-bit replacement tree plus victim selection.
// Assumes four ways; an invalid way (lowest index) overrides the tree.
module cache_tag_plru
    import cache_tag_pkg::*;
#(
    parameter int SETS = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [WAYS-1:0]     valid_vec,
    output logic [WAY_W-1:0]    victim,
    input  logic                upd_en,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic [WAY_W-1:0]    upd_way
);
    logic [TREE_W-1:0] tree_q [SETS];
    logic [TREE_W-1:0] cur;

    // Tree update on core hit or fill; reset clears all trees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            tree_q[upd_idx][0] <= (upd_way < 2'd2);
            if (upd_way < 2'd2) tree_q[upd_idx][1] <= (upd_way == 2'd0);
            else                tree_q[upd_idx][2] <= (upd_way == 2'd2);
        end
    end

    // Victim choice: first invalid way, else follow the tree.
    always_comb begin
        cur    = tree_q[rd_idx];
        victim = cur[0] ? (cur[2] ? 2'd3 : 2'd2) : (cur[1] ? 2'd1 : 2'd0);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_tag_arb.sv
// Shared-port arbiter: snoop first, a colliding core operation replays next clock.
// Assumes snoops are spaced so a replay is not pushed back more than once.
module cache_tag_arb #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_fill,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [1:0]        core_fill_state,
    input  logic              snp_req,
    output logic              go_core,
    output logic              go_snp,
    output logic              sel_fill,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [1:0]        sel_state,
    output logic              busy
);
    logic              pend_q;
    logic              fill_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        fst_q;

    // Pending flag: set on collision, held while snoops keep arriving.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (pend_q) pend_q <= snp_req;
        else             pend_q <= core_req && snp_req;
    end

    // Capture the deferred core operation on a collision.
    always_ff @(posedge clk) begin
        if (!pend_q && core_req && snp_req) begin
            fill_q <= core_fill;
            addr_q <= core_addr;
            fst_q  <= core_fill_state;
        end
    end

    // Port grant and operand select.
    always_comb begin
        go_snp    = snp_req;
        go_core   = !snp_req && (pend_q || core_req);
        sel_fill  = pend_q ? fill_q : core_fill;
        sel_addr  = pend_q ? addr_q : core_addr;
        sel_state = pend_q ? fst_q  : core_fill_state;
        busy      = pend_q;
    end
endmodule

// File: rtl/cache_tag_array.sv
// Top of the shared tag array: decodes addresses, arbitrates the port,
// applies fills and snoop invalidations, and registers both result paths.
// Assumes 32-byte lines and four ways; results are valid one clock after lookup.
module cache_tag_array
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SET_W  = 7,
    localparam int SETS  = 1 << SET_W,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_fill,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [1:0]        core_fill_state,
    output logic              core_busy,
    input  logic              snp_req,
    input  logic              snp_inv,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              core_rsp_valid,
    output logic              core_hit,
    output logic [1:0]        core_way,
    output logic [1:0]        core_state,
    output logic              snp_rsp_valid,
    output logic              snp_hit,
    output logic [1:0]        snp_way,
    output logic [1:0]        snp_state
);
    logic              go_core, go_snp, sel_fill;
    logic [ADDR_W-1:0] sel_addr, lk_addr;
    logic [1:0]        sel_state;
    logic [SET_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WAYS-1:0]   hit_vec, valid_vec;
    logic [WAYS-1:0][1:0] rd_state;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way, victim, wr_way;
    logic [1:0]        hit_state, wr_state;
    logic              wr_en, upd_en;

    cache_tag_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_fill(core_fill),
        .core_addr(core_addr), .core_fill_state(core_fill_state), .snp_req(snp_req),
        .go_core(go_core), .go_snp(go_snp), .sel_fill(sel_fill), .sel_addr(sel_addr),
        .sel_state(sel_state), .busy(core_busy)
    );

    // Lookup address decode for whichever side owns the port.
    always_comb begin
        lk_addr   = go_snp ? snp_addr : sel_addr;
        lk_idx    = lk_addr[OFF_W +: SET_W];
        lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
        any_hit   = |hit_vec;
        hit_way   = way_index(hit_vec);
        hit_state = rd_state[hit_way];
        for (int w = 0; w < WAYS; w++) valid_vec[w] = (rd_state[w] != LS_INVALID);
    end

    cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_idx), .rd_tag(lk_tag),
        .hit_vec(hit_vec), .rd_state(rd_state), .wr_en(wr_en), .wr_idx(lk_idx),
        .wr_way(wr_way), .wr_tag(lk_tag), .wr_state(wr_state)
    );

    cache_tag_plru #(.SETS(SETS)) u_plru (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_idx), .valid_vec(valid_vec),
        .victim(victim), .upd_en(upd_en), .upd_idx(lk_idx), .upd_way(wr_way)
    );

    // Write and replacement-update decisions for this clock.
    always_comb begin
        wr_en    = 1'b0;
        wr_way   = hit_way;
        wr_state = LS_INVALID;
        upd_en   = 1'b0;
        if (go_snp) begin
            wr_en = snp_inv && any_hit;
        end else if (go_core) begin
            upd_en = any_hit || sel_fill;
            if (sel_fill) begin
                wr_en    = 1'b1;
                wr_way   = any_hit ? hit_way : victim;
                wr_state = sel_state;
            end
        end
    end

    // Registered result paths, one per requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rsp_valid <= 1'b0;
            snp_rsp_valid  <= 1'b0;
            core_hit <= 1'b0; core_way <= '0; core_state <= '0;
            snp_hit  <= 1'b0; snp_way  <= '0; snp_state  <= '0;
        end else begin
            core_rsp_valid <= go_core;
            snp_rsp_valid  <= go_snp;
            if (go_core) begin
                core_hit   <= any_hit;
                core_way   <= (any_hit || sel_fill) ? wr_way : '0;
                core_state <= sel_fill ? sel_state : (any_hit ? hit_state : 2'b00);
            end
            if (go_snp) begin
                snp_hit   <= any_hit;
                snp_way   <= any_hit ? hit_way : '0;
                snp_state <= any_hit ? hit_state : 2'b00;
            end
        end
    end

    // R4: every snoop gets a result strobe on the next clock.
    p_snoop_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req |=> snp_rsp_valid);
    // R5: a collision defers the core side into a busy clock.
    p_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && snp_req && !core_busy) |=> core_busy);
    // R5: a busy clock without a snoop yields the deferred core result next.
    p_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && !snp_req) |=> (core_rsp_valid && !core_busy));
    // R5: the two result strobes never coincide.
    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rsp_valid && snp_rsp_valid));
endmodule

// File: tb/cache_tag_array_tb.sv
module cache_tag_array_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        core_req, core_fill, snp_req, snp_inv;
    logic [31:0] core_addr, snp_addr;
    logic [1:0]  core_fill_state;
    logic        core_busy, core_rsp_valid, core_hit, snp_rsp_valid, snp_hit;
    logic [1:0]  core_way, core_state, snp_way, snp_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model.
    logic [19:0] m_tag [128][4];
    logic [1:0]  m_st  [128][4];
    logic [2:0]  m_tree[128];

    always #10 clk = ~clk;

    cache_tag_array u_dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_fill(core_fill),
        .core_addr(core_addr), .core_fill_state(core_fill_state), .core_busy(core_busy),
        .snp_req(snp_req), .snp_inv(snp_inv), .snp_addr(snp_addr),
        .core_rsp_valid(core_rsp_valid), .core_hit(core_hit), .core_way(core_way),
        .core_state(core_state), .snp_rsp_valid(snp_rsp_valid), .snp_hit(snp_hit),
        .snp_way(snp_way), .snp_state(snp_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [19:0] t, input int s, input int off);
        return {t, 7'(s), 5'(off)};
    endfunction

    function automatic int m_find(input int s, input logic [19:0] t);
        for (int w = 0; w < 4; w++)
            if (m_st[s][w] != 2'b00 && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int m_victim(input int s);
        for (int w = 0; w < 4; w++) if (m_st[s][w] == 2'b00) return w;
        if (m_tree[s][0]) return m_tree[s][2] ? 3 : 2;
        return m_tree[s][1] ? 1 : 0;
    endfunction

    task automatic m_touch(input int s, input int w);
        m_tree[s][0] = (w < 2);
        if (w < 2) m_tree[s][1] = (w == 0);
        else       m_tree[s][2] = (w == 2);
    endtask

    // Drive one core operation and check its result one clock later.
    task automatic core_op(input string req, input logic [31:0] a, input bit fill, input logic [1:0] st);
        int s, f, w;
        s = int'(a[11:5]);
        f = m_find(s, a[31:12]);
        core_req = 1'b1; core_fill = fill; core_addr = a; core_fill_state = st;
        @(posedge clk); @(negedge clk);
        core_req = 1'b0; core_fill = 1'b0;
        check(req, core_rsp_valid, 1);
        check(req, core_hit, f >= 0);
        if (fill) begin
            w = (f >= 0) ? f : m_victim(s);
            check(req, core_way, w);
            check(req, core_state, st);
            m_tag[s][w] = a[31:12]; m_st[s][w] = st; m_touch(s, w);
        end else begin
            check(req, core_way, (f >= 0) ? f : 0);
            check(req, core_state, (f >= 0) ? m_st[s][f] : 0);
            if (f >= 0) m_touch(s, f);
        end
    endtask

    // Drive one snoop and check its result one clock later.
    task automatic snoop_op(input string req, input logic [31:0] a, input bit inv);
        int s, f;
        s = int'(a[11:5]);
        f = m_find(s, a[31:12]);
        snp_req = 1'b1; snp_inv = inv; snp_addr = a;
        @(posedge clk); @(negedge clk);
        snp_req = 1'b0; snp_inv = 1'b0;
        check(req, snp_rsp_valid, 1);
        check(req, snp_hit, f >= 0);
        check(req, snp_way, (f >= 0) ? f : 0);
        check(req, snp_state, (f >= 0) ? m_st[s][f] : 0);
        if (f >= 0 && inv) m_st[s][f] = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int sets[4];
        int w0;
        sets = '{0, 1, 64, 127};
        for (int s = 0; s < 128; s++) begin
            m_tree[s] = 3'b000;
            for (int w = 0; w < 4; w++) begin m_st[s][w] = 2'b00; m_tag[s][w] = '0; end
        end
        rst_n = 1'b0; core_req = 0; core_fill = 0; core_addr = 0; core_fill_state = 0;
        snp_req = 0; snp_inv = 0; snp_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset outputs.
        check("R1", core_rsp_valid, 0);
        check("R1", snp_rsp_valid, 0);
        check("R1", core_busy, 0);
        core_op("R1", mk(20'h00001, 9, 0), 0, 0);

        // R9 R11: fill four ways per chosen set with mixed states.
        foreach (sets[i])
            for (int k = 0; k < 4; k++)
                core_op("R9", mk(20'h10 + 20'(k), sets[i], 0), 1, 2'((k % 3) + 1));
        // R2 R3: lookups with varying offsets all hit.
        foreach (sets[i])
            for (int k = 0; k < 4; k++)
                core_op("R2", mk(20'h10 + 20'(k), sets[i], k * 7 + 1), 0, 0);
        core_op("R3", mk(20'hABCDE, 64, 0), 0, 0);

        // R10: eviction chain in set 1 with touches between fills.
        core_op("R10", mk(20'h11, 1, 0), 0, 0);
        for (int k = 0; k < 8; k++) begin
            core_op("R10", mk(20'h200 + 20'(k), 1, 0), 1, 2'b01);
            core_op("R10", mk(20'h200 + 20'(k), 1, 3), 0, 0);
            if (k % 3 == 0) core_op("R10", mk(m_tag[1][k % 4], 1, 0), 0, 0);
        end

        // R4 R8: snoop hit does not move the tree in set 127.
        snoop_op("R4", mk(m_tag[127][m_victim(127)], 127, 4), 0);
        core_op("R8", mk(20'h300, 127, 0), 1, 2'b10);

        // R4 R7: invalidate a modified line in set 64, then miss.
        snoop_op("R4", mk(20'h12, 64, 0), 0);
        snoop_op("R7", mk(20'h12, 64, 0), 1);
        core_op("R7", mk(20'h12, 64, 0), 0, 0);
        core_op("R9", mk(20'h301, 64, 0), 1, 2'b01);
        snoop_op("R4", mk(20'h777, 64, 0), 1);

        // R12: refill of a present line overwrites in place.
        core_op("R12", mk(20'h13, 0, 0), 1, 2'b11);
        core_op("R12", mk(20'h13, 0, 0), 0, 0);

        // R5 R6 R7: collision; snoop invalidates the line the core wants.
        w0 = m_find(0, 20'h13);
        core_req = 1; core_fill = 0; core_addr = mk(20'h13, 0, 0);
        snp_req = 1; snp_inv = 1; snp_addr = mk(20'h13, 0, 8);
        @(posedge clk); @(negedge clk);
        check("R5", snp_rsp_valid, 1);
        check("R5", snp_hit, 1);
        check("R5", snp_way, w0);
        check("R5", snp_state, 2'b11);
        check("R5", core_rsp_valid, 0);
        check("R5", core_busy, 1);
        m_st[0][w0] = 2'b00;
        snp_req = 0; snp_inv = 0;
        core_req = 1; core_fill = 1; core_fill_state = 2'b10; core_addr = mk(20'h555, 0, 0);
        @(posedge clk); @(negedge clk);
        core_req = 0; core_fill = 0;
        check("R5", core_rsp_valid, 1);
        check("R7", core_hit, 0);
        check("R5", core_busy, 0);
        @(posedge clk); @(negedge clk);
        check("R6", core_rsp_valid, 0);
        core_op("R6", mk(20'h555, 0, 0), 0, 0);

        // R2 R9: sweep every set with a single fill and lookup.
        for (int s = 0; s < 128; s++) begin
            core_op("R9", mk(20'hF0000 ^ 20'(s), s, 0), 1, 2'b01);
            core_op("R2", mk(20'hF0000 ^ 20'(s), s, 31), 0, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule